// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block keeps the status byte of a serial EEPROM and decides, request by request, whether the host may rewrite that byte or write into the array. The SPI command engine sends it one-cycle strobes: write-enable latch set, latch clear, status write with its data byte, array write with its target address, and a start pulse. The start pulse is raised when chip select rises after a complete write sequence. The active-low write-protect pin is also an input. The block answers each status or array write request with a one-cycle grant or deny. On a start pulse that follows a granted request, it runs a self-timed write cycle and reports busy for its whole length.

Two controls decide whether a write is allowed. The two block-protect bits choose how much of the top of the array can only be read. The write-protect-enable bit arms the pin, so that a low pin locks the status register. Unprotected array space stays writable while the status register is locked. The nonvolatile protect bits are held in ordinary flops that load fixed values at reset. The length of the write cycle and the power-up lockout are parameters counted in clock cycles.

Top module: `eep_wprot`

## Requirements
- R1: `status_q` packs the status as bit 7 = protect-enable, bits 6..4 = 0, bit 3 = block-protect high, bit 2 = block-protect low, bit 1 = write-enable latch, bit 0 = busy. All fields are 0 after reset.
- R2: When the block is idle, `cmd_wren` sets the write-enable latch and `cmd_wrdi` clears it. The change shows in `status_q[1]` one cycle later.
- R3: The block-protect code chooses the protected addresses. With an array of 2^ADDR_W bytes: 00 protects none, 01 protects the top quarter (from 3·2^ADDR_W/4 up), 10 protects the top half (from 2^ADDR_W/2 up), and 11 protects every address. A write request to a protected address is always denied.
- R4: Hardware lock is active when protect-enable is 1 and `wp_n` is 0. While it is active, every status write request is denied, even with the latch set.
- R5: A status write request is granted exactly when the latch is 1, the hardware lock is inactive and the power-up lockout is over. After the write cycle, bit 7 and bits 3..2 of the data show in the status. The data's bits 6..4 and 1..0 have no effect.
- R6: A write request to an unprotected address is granted exactly when the latch is 1 and the lockout is over. This holds whatever the state of `wp_n` and protect-enable.
- R7: A denied request clears the write-enable latch.
- R8: A start pulse that follows a granted request, with no other command in between, raises `busy` on the next cycle. `busy` stays high for exactly WRITE_CYC cycles. When it falls, the latch is 0 and any status write has been applied.
- R9: A start pulse with no granted request pending does not raise `busy` and leaves the status unchanged.
- R10: While `busy` is 1, every command strobe and start pulse is ignored. No grant or deny is issued, and the protect bits and the latch hold until the cycle ends. The status byte stays readable.
- R11: For PWRUP_CYC cycles after reset, every status or array write request is denied.
- R12: Each status or array write request gets exactly one of grant or deny, one cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wp_n | input | 1 | Write-protect pin, active low, synchronous to clk |
| cmd_wren | input | 1 | Strobe: set write-enable latch |
| cmd_wrdi | input | 1 | Strobe: clear write-enable latch |
| cmd_wrsr | input | 1 | Strobe: status write request |
| wrsr_data | input | 8 | Data byte for the status write |
| cmd_write | input | 1 | Strobe: array write request |
| write_addr | input | ADDR_W | Byte address of the array write |
| start_wr | input | 1 | Start the write cycle of the granted request |
| status_q | output | 8 | Status byte for status reads |
| wrsr_grant | output | 1 | Status write request granted |
| wrsr_deny | output | 1 | Status write request denied |
| write_grant | output | 1 | Array write request granted |
| write_deny | output | 1 | Array write request denied |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
Some properties are checked on every cycle. No grant can appear with the latch clear, during the power-up lockout, into a protected zone or, for the status, under hardware lock. Grant and deny never appear together. Every busy period lasts exactly WRITE_CYC cycles, and the protect bits and latch hold still through it. Other behaviour shows only in the bench's scenarios. The exact protection boundaries for each block-protect code come from a sweep of addresses across the whole array. The bench also checks that the data bits which must be ignored really are ignored. It checks that commands given during busy leave no trace once the cycle ends, and that a stray start pulse does nothing.

// File: rtl/eep_wprot_pkg.sv
package eep_wprot_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_STAT = 2'd1,
    OP_ARR  = 2'd2
  } wop_e;

  typedef enum logic [2:0] {
    C_IDLE  = 3'd0,
    C_WRDI  = 3'd1,
    C_WREN  = 3'd2,
    C_WRSR  = 3'd3,
    C_WRITE = 3'd4,
    C_START = 3'd5
  } cmd_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nv_t;

  // one command per cycle; clearing the latch wins over everything
  function automatic cmd_e pick_cmd(input logic wrdi, input logic wren,
                                    input logic wrsr, input logic wr,
                                    input logic start);
    if (wrdi)       return C_WRDI;
    else if (wren)  return C_WREN;
    else if (wrsr)  return C_WRSR;
    else if (wr)    return C_WRITE;
    else if (start) return C_START;
    return C_IDLE;
  endfunction

  // lowest protected address for a block-protect code in an array of 2^aw bytes
  function automatic logic [31:0] zone_floor(input logic [1:0] bp, input int aw);
    logic [31:0] span;
    span = 32'd1 << aw;
    case (bp)
      2'b01:   return span - (span >> 2);
      2'b10:   return span >> 1;
      2'b11:   return 32'd0;
      default: return span;
    endcase
  endfunction

  function automatic logic zone_locked(input logic [1:0] bp, input logic [31:0] addr,
                                       input int aw);
    return (bp != 2'b00) && (addr >= zone_floor(bp, aw));
  endfunction

  function automatic nv_t unpack_nv(input logic [7:0] d);
    nv_t n;
    n.wpen = d[7];
    n.bp   = d[3:2];
    return n;
  endfunction

  function automatic logic [7:0] pack_status(input nv_t nv, input logic wel,
                                             input logic busy);
    return {nv.wpen, 3'b000, nv.bp, wel, busy};
  endfunction

endpackage

// File: rtl/eep_wprot_guard.sv
module eep_wprot_guard
  import eep_wprot_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nv_t               nv,
  input  logic              wel,
  input  logic              wp_n,
  input  logic              lockout,
  input  logic [ADDR_W-1:0] addr,
  output logic              hw_lock,
  output logic              zone_hit,
  output logic              stat_ok,
  output logic              arr_ok
);

  logic [31:0] addr_ext;

  always_comb begin
    addr_ext = 32'(addr);
    hw_lock  = nv.wpen && !wp_n;
    zone_hit = zone_locked(nv.bp, addr_ext, ADDR_W);
    stat_ok  = wel && !hw_lock && !lockout;
    arr_ok   = wel && !zone_hit && !lockout;
  end

  p_hw_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |-> !stat_ok);

  p_zone_deny_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zone_hit |-> !arr_ok);

  p_full_zone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nv.bp == 2'b11) |-> zone_hit);

  p_need_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |-> !(stat_ok || arr_ok));

  p_lockout_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> !(stat_ok || arr_ok));

endmodule

// File: rtl/eep_wprot_timer.sv
module eep_wprot_timer #(
  parameter int WRITE_CYC = 250000,
  parameter int PWRUP_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic lockout
);

  localparam int WCW = $clog2(WRITE_CYC + 1);
  localparam int PCW = $clog2(PWRUP_CYC + 1);

  logic [WCW-1:0] wcnt;
  logic [PCW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= PCW'(PWRUP_CYC);
    end else if (pcnt != '0) begin
      pcnt <= pcnt - 1'b1;
    end
  end

  assign lockout = (pcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wcnt <= '0;
    end else if (!busy && start) begin
      busy <= 1'b1;
      wcnt <= WCW'(WRITE_CYC - 1);
    end else if (busy) begin
      if (wcnt == '0) busy <= 1'b0;
      else            wcnt <= wcnt - 1'b1;
    end
  end

  assign done = busy && (wcnt == '0);

  // length of the busy period, measured independently of wcnt
  logic [31:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 32'(WRITE_CYC)));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_lock_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lockout |=> !lockout);

endmodule

// File: rtl/eep_wprot_statreg.sv
module eep_wprot_statreg
  import eep_wprot_pkg::*;
#(
  parameter logic       RST_WPEN = 1'b0,
  parameter logic [1:0] RST_BP   = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic [7:0] wrsr_data,
  input  logic       stat_ok,
  input  logic       arr_ok,
  input  logic       busy,
  input  logic       done,
  output nv_t        nv,
  output logic       wel,
  output logic       fire,
  output logic       sr_grant,
  output logic       sr_deny,
  output logic       ar_grant,
  output logic       ar_deny
);

  wop_e pend;
  wop_e run_op;
  nv_t  stage;

  assign fire = !busy && (cmd == C_START) && (pend != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv       <= '{wpen: RST_WPEN, bp: RST_BP};
      wel      <= 1'b0;
      pend     <= OP_NONE;
      run_op   <= OP_NONE;
      stage    <= '0;
      sr_grant <= 1'b0;
      sr_deny  <= 1'b0;
      ar_grant <= 1'b0;
      ar_deny  <= 1'b0;
    end else begin
      sr_grant <= 1'b0;
      sr_deny  <= 1'b0;
      ar_grant <= 1'b0;
      ar_deny  <= 1'b0;
      if (busy) begin
        if (done) begin
          wel    <= 1'b0;
          run_op <= OP_NONE;
          if (run_op == OP_STAT) nv <= stage;
        end
      end else begin
        unique case (cmd)
          C_WREN: begin
            wel  <= 1'b1;
            pend <= OP_NONE;
          end
          C_WRDI: begin
            wel  <= 1'b0;
            pend <= OP_NONE;
          end
          C_WRSR: begin
            if (stat_ok) begin
              pend     <= OP_STAT;
              stage    <= unpack_nv(wrsr_data);
              sr_grant <= 1'b1;
            end else begin
              pend    <= OP_NONE;
              wel     <= 1'b0;
              sr_deny <= 1'b1;
            end
          end
          C_WRITE: begin
            if (arr_ok) begin
              pend     <= OP_ARR;
              ar_grant <= 1'b1;
            end else begin
              pend    <= OP_NONE;
              wel     <= 1'b0;
              ar_deny <= 1'b1;
            end
          end
          C_START: begin
            run_op <= pend;
            pend   <= OP_NONE;
          end
          default: ;
        endcase
      end
    end
  end

  p_grant_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant || ar_grant) |-> wel);

  p_deny_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_deny || ar_deny) |-> !wel);

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wel);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(nv) && $stable(wel)));

  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !(sr_grant || sr_deny || ar_grant || ar_deny));

endmodule

// File: rtl/eep_wprot.sv
module eep_wprot
  import eep_wprot_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         WRITE_CYC = 250000,
  parameter int         PWRUP_CYC = 50000,
  parameter logic       RST_WPEN  = 1'b0,
  parameter logic [1:0] RST_BP    = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] write_addr,
  input  logic              start_wr,
  output logic [7:0]        status_q,
  output logic              wrsr_grant,
  output logic              wrsr_deny,
  output logic              write_grant,
  output logic              write_deny,
  output logic              busy
);

  cmd_e cmd;
  nv_t  nv;
  logic wel, fire, done, lockout;
  logic hw_lock, zone_hit, stat_ok, arr_ok;

  assign cmd = pick_cmd(cmd_wrdi, cmd_wren, cmd_wrsr, cmd_write, start_wr);

  eep_wprot_timer #(
    .WRITE_CYC(WRITE_CYC),
    .PWRUP_CYC(PWRUP_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (fire),
    .busy   (busy),
    .done   (done),
    .lockout(lockout)
  );

  eep_wprot_guard #(
    .ADDR_W(ADDR_W)
  ) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .nv      (nv),
    .wel     (wel),
    .wp_n    (wp_n),
    .lockout (lockout),
    .addr    (write_addr),
    .hw_lock (hw_lock),
    .zone_hit(zone_hit),
    .stat_ok (stat_ok),
    .arr_ok  (arr_ok)
  );

  eep_wprot_statreg #(
    .RST_WPEN(RST_WPEN),
    .RST_BP  (RST_BP)
  ) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .wrsr_data(wrsr_data),
    .stat_ok  (stat_ok),
    .arr_ok   (arr_ok),
    .busy     (busy),
    .done     (done),
    .nv       (nv),
    .wel      (wel),
    .fire     (fire),
    .sr_grant (wrsr_grant),
    .sr_deny  (wrsr_deny),
    .ar_grant (write_grant),
    .ar_deny  (write_deny)
  );

  assign status_q = pack_status(nv, wel, busy);

  p_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[6:4] == 3'b000) && (status_q[0] == busy));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrsr_grant && wrsr_deny) && !(write_grant && write_deny));

  p_sr_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_grant || wrsr_deny) |-> $past(cmd_wrsr));

  p_lock_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> !busy);

  p_hw_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && !cmd_wrdi && !cmd_wren && !busy && hw_lock) |=> !wrsr_grant);

endmodule

// File: tb/eep_wprot_bench.sv
module eep_wprot_bench;

  localparam int AW = 10;
  localparam int WC = 8;
  localparam int PC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, start_wr = 0;
  logic [7:0] wrsr_data = '0;
  logic [AW-1:0] write_addr = '0;
  logic [7:0] status_q;
  logic wrsr_grant, wrsr_deny, write_grant, write_deny, busy;

  int n_cmp = 0;
  int n_bad = 0;

  logic       m_wpen = 0;
  logic [1:0] m_bp = 0;
  logic       m_wel = 0;

  always #10 clk = ~clk;

  eep_wprot #(.ADDR_W(AW), .WRITE_CYC(WC), .PWRUP_CYC(PC)) u_eep_wprot (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_write(cmd_write),
    .write_addr(write_addr), .start_wr(start_wr), .status_q(status_q),
    .wrsr_grant(wrsr_grant), .wrsr_deny(wrsr_deny), .write_grant(write_grant),
    .write_deny(write_deny), .busy(busy));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(input logic b);
    return {m_wpen, 3'b000, m_bp, m_wel, b};
  endfunction

  function automatic bit in_zone(input logic [1:0] bp, input int a);
    int size = 1 << AW;
    if (bp == 2'd3) return 1;
    if (bp == 2'd2) return a >= size / 2;
    if (bp == 2'd1) return a >= (size / 4) * 3;
    return 0;
  endfunction

  // one strobe: raised at a falling edge, outputs read at the next falling edge
  task automatic strobe(input int kind, input logic [7:0] d, input int a);
    cmd_wren   = (kind == 0);
    cmd_wrdi   = (kind == 1);
    cmd_wrsr   = (kind == 2);
    cmd_write  = (kind == 3);
    start_wr   = (kind == 4);
    wrsr_data  = d;
    write_addr = AW'(a);
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0; start_wr = 0;
  endtask

  task automatic do_wren();
    strobe(0, 8'h00, 0);
    m_wel = 1;
    chk(status_q == exp_stat(0), "R2 wren", status_q, exp_stat(0));
  endtask

  task automatic do_wrdi();
    strobe(1, 8'h00, 0);
    m_wel = 0;
    chk(status_q == exp_stat(0), "R2 wrdi", status_q, exp_stat(0));
  endtask

  task automatic try_wrsr(input logic [7:0] d, input bit ok, input string req);
    strobe(2, d, 0);
    chk(wrsr_grant == ok && wrsr_deny == !ok, req, {wrsr_grant, wrsr_deny}, {ok, !ok});
    if (!ok) m_wel = 0;
    chk(status_q == exp_stat(0), "R7 latch after status request", status_q, exp_stat(0));
  endtask

  task automatic try_write(input int a, input bit ok, input string req);
    strobe(3, 8'h00, a);
    chk(write_grant == ok && write_deny == !ok, req, {write_grant, write_deny}, {ok, !ok});
    if (!ok) m_wel = 0;
    chk(status_q == exp_stat(0), "R7 latch after array request", status_q, exp_stat(0));
  endtask

  // start a granted cycle, measure busy, apply the model's effects
  task automatic run_cycle(input bit is_stat, input logic [7:0] d);
    int n = 0;
    strobe(4, 8'h00, 0);
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == WC, "R8 busy length", n, WC);
    m_wel = 0;
    if (is_stat) begin
      m_wpen = d[7];
      m_bp   = d[3:2];
    end
    chk(status_q == exp_stat(0), "R8/R5 status after cycle", status_q, exp_stat(0));
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status_q == 8'h00, "R1 reset status", status_q, 8'h00);
    chk(busy == 0, "R1 reset busy", busy, 0);
    rst_n = 1;
    @(negedge clk);

    // power-up lockout
    do_wren();
    try_write(0, 0, "R11 array write in lockout");
    do_wren();
    try_wrsr(8'h00, 0, "R11 status write in lockout");
    repeat (PC + 5) @(negedge clk);

    do_wren();
    do_wrdi();
    try_wrsr(8'h04, 0, "R5 status write without latch");
    try_write(0, 0, "R6 array write without latch");

    // sweep every protect code across the array
    for (int bp = 0; bp < 4; bp++) begin
      logic [7:0] d;
      d = 8'h73 | 8'(bp << 2);
      do_wren();
      try_wrsr(d, 1, "R5 status write granted");
      run_cycle(1, d);
      chk(status_q[6:4] == 3'b000 && status_q[3:2] == 2'(bp), "R5 ignored bits",
          status_q, {4'b0, 2'(bp), 2'b0});
      for (int a = 0; a < (1 << AW); a += 32) begin
        do_wren();
        try_write(a, !in_zone(2'(bp), a), "R3 zone sweep");
      end
      for (int k = 0; k < 4; k++) begin
        int edges[4] = '{511, 512, 767, 768};
        do_wren();
        try_write(edges[k], !in_zone(2'(bp), edges[k]), "R3 zone boundary");
      end
      do_wren();
      try_write((1 << AW) - 1, !in_zone(2'(bp), (1 << AW) - 1), "R3 last address");
    end

    // hardware lock: protect-enable on, quarter protected
    do_wren();
    try_wrsr(8'h84, 1, "R5 set protect-enable");
    run_cycle(1, 8'h84);
    wp_n = 0;
    do_wren();
    try_write(0, 1, "R6 unprotected write under hardware lock");
    do_wren();
    try_write(800, 0, "R3 protected write under hardware lock");
    do_wren();
    try_wrsr(8'h00, 0, "R4 status locked by pin");
    wp_n = 1;
    do_wren();
    try_wrsr(8'h00, 1, "R4 pin high releases status");
    run_cycle(1, 8'h00);

    // array write cycle
    do_wren();
    try_write(5, 1, "R6 array grant");
    run_cycle(0, 8'h00);

    // stray start
    do_wrdi();
    strobe(4, 8'h00, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && status_q == exp_stat(0), "R9 stray start", status_q, exp_stat(0));
    do_wren();
    strobe(4, 8'h00, 0);
    chk(busy == 0, "R9 start after only wren", busy, 0);

    // commands during busy
    try_write(3, 1, "R6 array grant before busy");
    strobe(4, 8'h00, 0);
    chk(busy == 1, "R8 busy raised", busy, 1);
    strobe(1, 8'h00, 0);
    chk(status_q == exp_stat(1) && !wrsr_grant && !wrsr_deny, "R10 wrdi ignored",
        status_q, exp_stat(1));
    strobe(2, 8'h8C, 0);
    chk(!wrsr_grant && !wrsr_deny, "R10 status request ignored", {wrsr_grant, wrsr_deny}, 0);
    strobe(3, 8'h00, 900);
    chk(!write_grant && !write_deny, "R10 array request ignored",
        {write_grant, write_deny}, 0);
    strobe(4, 8'h00, 0);
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    m_wel = 0;
    chk(status_q == exp_stat(0), "R10 nothing applied from busy period",
        status_q, exp_stat(0));
    repeat (2) @(negedge clk);
    chk(busy == 0, "R10 start during busy dropped", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule